// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the processor-side register file and interrupt logic of a two-channel serial controller. Each channel exposes a control port and a data port on a byte-wide synchronous bus. Control registers are reached indirectly: software first loads a per-channel register pointer through control register 0, and the next control access uses that pointer. Every access then sends the pointer back to register 0. The block stores sixteen write registers per channel and a small set of readable status registers. It also keeps the receive and transmit pending and in-service state, a shared interrupt vector and one interrupt line.

Received bytes and break pulses arrive from a line engine outside the block. Bytes written to a data port are handed outward with a one-cycle strobe when that channel's transmitter is enabled. Bit timing, baud generation, synchronous modes and DMA belong to other blocks.

Top module: `dual_serial_regs`

## Requirements
- R1: Address bit SHIFT selects control (0) or data (1), and bit SHIFT+1 selects the channel (0 = channel B, 1 = channel A). The two channels keep separate registers.
- R2: A control write while the pointer is 0 loads pointer bits 2:0 from data bits 2:0. When data bits 5:3 are 001, pointer bit 3 is also set.
- R3: A control write to a nonzero pointer stores the byte and clears the pointer. Every control read returns the addressed read register and clears the pointer.
- R4: Writing 0x28 to register 0 clears the transmit interrupt of that channel. Writing 0x38 clears the receive interrupt if receive is in service, or otherwise clears the transmit interrupt if transmit is in service.
- R5: A new pending source takes the in-service state only if the other source of the same channel is not in service. Clearing one source re-raises the other if that source is still pending.
- R6: The vector is read as channel B register 2. With register 9 bit 4 of the raising channel set, the codes are rx A 0x30, rx B 0x20, tx A 0x10 and idle 0x60. With that bit clear, they are rx A 0x0C, rx B 0x04, tx A 0x08 and idle 0x06. Tx B is always 0x00.
- R7: Channel A read register 3 shows the pending bits: bit 1 tx B, bit 2 rx B, bit 4 tx A, bit 5 rx A.
- R8: irq is the OR over both channels of three terms: (register 1 bit 1 and tx pending), (register 1 bits 4:3 equal 01 or 10, and rx pending), and (register 15 bit 7 and status bit 7).
- R9: Writing register 9 with bits 7:6 = 01 resets B, 10 resets A and 11 resets both; 00 stores the byte. After any reset, write registers 4/9/11/14/15 = 0x04/0xC0/0x08/0x30/0xF8, status = 0x44, register 1 = 0x07, and all other state is 0.
- R10: A data write sets status bit 2 and register 1 bit 0 and raises a transmit interrupt. It pulses tx_strobe for that channel (bit 1 = A) with tx_byte on the next cycle only if write register 5 bit 3 is set.
- R11: A data read returns the last accepted byte, clears status bit 0 and clears the receive interrupt.
- R12: A rx_valid pulse is accepted only when write register 3 bit 0 is set and status bit 0 is clear. Acceptance sets status bit 0 and raises a receive interrupt.
- R13: Writes to registers 12 and 13 also appear in read registers 12 and 13.
- R14: Read data is registered and valid in the cycle after the rd strobe. A brk pulse sets status bit 7, which stays set until a channel reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of both channels |
| addr | input | SHIFT+2 | Bus address (port and channel select) |
| wdata | input | 8 | Write data |
| wr | input | 1 | Single-cycle write strobe |
| rd | input | 1 | Single-cycle read strobe |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt request |
| rx_valid | input | 2 | Received-byte pulse per channel (bit 1 = A) |
| rx_data | input | 16 | Received bytes, channel B in 7:0, A in 15:8 |
| brk | input | 2 | Break pulse per channel (bit 1 = A) |
| tx_strobe | output | 2 | Transmit byte strobe per channel (bit 1 = A) |
| tx_byte | output | 8 | Last forwarded transmit byte |

## Verification
The bench first drives each channel with lone receive and lone transmit events. These show whether the vector, the channel A pending register and irq follow the correct channel. Next it overlaps a transmit in service with a later receive on the same channel, so a wrong arbitration order or a missing re-raise becomes visible in the vector after each acknowledge command. The same patterns are then repeated with the status-high bit set, which separates the two vector code sets. Finally, break, single-channel reset and full reset show whether state is cleared for the correct channel only.

// File: rtl/dual_serial_regs.sv
module dual_serial_regs #(
  parameter int SHIFT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SHIFT+1:0] addr,
  input  logic [7:0]       wdata,
  input  logic             wr,
  input  logic             rd,
  output logic [7:0]       rdata,
  output logic             irq,
  input  logic [1:0]       rx_valid,
  input  logic [15:0]      rx_data,
  input  logic [1:0]       brk,
  output logic [1:0]       tx_strobe,
  output logic [7:0]       tx_byte
);
  typedef struct packed {
    logic [1:0] rxi, txi, rxs, txs;
    logic [7:0] vec;
    logic [5:0] rr3;
  } ist_t;

  function automatic logic [7:0] code(input logic c, input logic [1:0] src, input logic hi);
    case (src)
      2'd1:    return c ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
      2'd2:    return c ? (hi ? 8'h10 : 8'h08) : 8'h00;
      default: return hi ? 8'h60 : 8'h06;
    endcase
  endfunction

  function automatic ist_t set_rx(input ist_t s, input logic c, input logic hi);
    s.rxi[c] = 1'b1;
    if (!s.txs[c]) begin s.rxs[c] = 1'b1; s.vec = code(c, 2'd1, hi); end
    s.rr3[c ? 5 : 2] = 1'b1;
    return s;
  endfunction

  function automatic ist_t set_tx(input ist_t s, input logic c, input logic hi);
    s.txi[c] = 1'b1;
    if (!s.rxs[c]) begin s.txs[c] = 1'b1; s.vec = code(c, 2'd2, hi); end
    s.rr3[c ? 4 : 1] = 1'b1;
    return s;
  endfunction

  function automatic ist_t clr_rx(input ist_t s, input logic c, input logic hi);
    s.rxi[c] = 1'b0; s.rxs[c] = 1'b0;
    s.vec = code(c, 2'd0, hi);
    s.rr3[c ? 5 : 2] = 1'b0;
    if (s.txi[c]) s = set_tx(s, c, hi);
    return s;
  endfunction

  function automatic ist_t clr_tx(input ist_t s, input logic c, input logic hi);
    s.txi[c] = 1'b0; s.txs[c] = 1'b0;
    s.vec = code(c, 2'd0, hi);
    s.rr3[c ? 4 : 1] = 1'b0;
    if (s.rxi[c]) s = set_rx(s, c, hi);
    return s;
  endfunction

  function automatic logic [7:0] wdef(input int r);
    case (r)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] wreg_q [2][16], wreg_d [2][16];
  logic [7:0] rr0_q [2], rr0_d [2], rr1_q [2], rr1_d [2];
  logic [7:0] rr12_q [2], rr12_d [2], rr13_q [2], rr13_d [2];
  logic [7:0] rxd_q [2], rxd_d [2];
  logic [3:0] ptr_q [2], ptr_d [2];
  ist_t       st_q, st_d;
  logic [7:0] rdata_d, tx_byte_d;
  logic [1:0] tx_stb_d, rst_mask;

  wire       ch  = addr[SHIFT+1];
  wire       dp  = addr[SHIFT];
  wire       hi  = wreg_q[ch][9][4];
  wire [3:0] ptr = ptr_q[ch];

  always_comb begin
    wreg_d = wreg_q; rr0_d = rr0_q; rr1_d = rr1_q; rr12_d = rr12_q; rr13_d = rr13_q;
    rxd_d = rxd_q; ptr_d = ptr_q; st_d = st_q;
    rdata_d = rdata; tx_byte_d = tx_byte; tx_stb_d = '0; rst_mask = '0;
    if (wr && !dp) begin
      if (ptr == 4'd0) begin
        ptr_d[ch] = {wdata[5:3] == 3'b001, wdata[2:0]};
        if (wdata[5:3] == 3'b101) st_d = clr_tx(st_d, ch, hi);
        else if (wdata[5:3] == 3'b111) begin
          if (st_d.rxs[ch]) st_d = clr_rx(st_d, ch, hi);
          else if (st_d.txs[ch]) st_d = clr_tx(st_d, ch, hi);
        end
      end else begin
        ptr_d[ch] = 4'd0;
        if (ptr == 4'd9 && wdata[7:6] != 2'b00) rst_mask = wdata[7:6];
        else wreg_d[ch][ptr] = wdata;
        if (ptr == 4'd12) rr12_d[ch] = wdata;
        if (ptr == 4'd13) rr13_d[ch] = wdata;
      end
    end
    if (wr && dp) begin
      tx_stb_d[ch] = wreg_q[ch][5][3];
      if (wreg_q[ch][5][3]) tx_byte_d = wdata;
      rr0_d[ch][2] = 1'b1;
      rr1_d[ch][0] = 1'b1;
      st_d = set_tx(st_d, ch, hi);
    end
    if (rd && !dp) begin
      ptr_d[ch] = 4'd0;
      case (ptr)
        4'd0:    rdata_d = rr0_q[ch];
        4'd1:    rdata_d = rr1_q[ch];
        4'd2:    rdata_d = ch ? 8'h00 : st_q.vec;
        4'd3:    rdata_d = ch ? {2'b00, st_q.rr3} : 8'h00;
        4'd12:   rdata_d = rr12_q[ch];
        4'd13:   rdata_d = rr13_q[ch];
        default: rdata_d = 8'h00;
      endcase
    end
    if (rd && dp) begin
      rdata_d = rxd_q[ch];
      rr0_d[ch][0] = 1'b0;
      st_d = clr_rx(st_d, ch, hi);
    end
    for (int c = 0; c < 2; c++) begin
      if (rst_mask[c]) begin
        for (int r = 0; r < 16; r++) wreg_d[c][r] = wdef(r);
        rr0_d[c] = 8'h44; rr1_d[c] = 8'h07; rr12_d[c] = '0; rr13_d[c] = '0;
        rxd_d[c] = '0; ptr_d[c] = '0;
        st_d.rxi[c] = 1'b0; st_d.txi[c] = 1'b0; st_d.rxs[c] = 1'b0; st_d.txs[c] = 1'b0;
        if (c == 0) st_d.vec = '0;
        else st_d.rr3 = '0;
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (rx_valid[c] && wreg_d[c][3][0] && !rr0_d[c][0]) begin
        rr0_d[c][0] = 1'b1;
        rxd_d[c] = rx_data[c*8 +: 8];
        st_d = set_rx(st_d, c[0], wreg_d[c][9][4]);
      end
      if (brk[c]) rr0_d[c][7] = 1'b1;
    end
  end

  always_comb begin
    irq = 1'b0;
    for (int c = 0; c < 2; c++)
      irq = irq | (wreg_q[c][1][1] & st_q.txi[c])
                | ((wreg_q[c][1][4] ^ wreg_q[c][1][3]) & st_q.rxi[c])
                | (wreg_q[c][15][7] & rr0_q[c][7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        for (int r = 0; r < 16; r++) wreg_q[c][r] <= wdef(r);
        rr0_q[c] <= 8'h44; rr1_q[c] <= 8'h07; rr12_q[c] <= '0; rr13_q[c] <= '0;
        rxd_q[c] <= '0; ptr_q[c] <= '0;
      end
      st_q <= '0; rdata <= '0; tx_strobe <= '0; tx_byte <= '0;
    end else begin
      wreg_q <= wreg_d; rr0_q <= rr0_d; rr1_q <= rr1_d; rr12_q <= rr12_d; rr13_q <= rr13_d;
      rxd_q <= rxd_d; ptr_q <= ptr_d; st_q <= st_d;
      rdata <= rdata_d; tx_strobe <= tx_stb_d; tx_byte <= tx_byte_d;
    end
  end
endmodule

// File: rtl/dual_serial_regs_chk.sv
module dual_serial_regs_chk #(
  parameter int SHIFT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SHIFT+1:0] addr,
  input logic             wr,
  input logic             rd,
  input logic [1:0]       rx_valid,
  input logic [1:0]       brk,
  input logic [1:0]       tx_strobe,
  input logic [7:0]       rr0_b,
  input logic [7:0]       rr0_a,
  input logic [3:0]       ptr_b,
  input logic [3:0]       ptr_a,
  input logic [7:0]       vec
);
  assert_tx_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_strobe != 2'b00) |-> $past(wr && addr[SHIFT]));
  assert_tx_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_strobe));
  assert_ptr_clear_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && !addr[SHIFT] && !addr[SHIFT+1]) |=> (ptr_b == 4'd0));
  assert_ptr_clear_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && !addr[SHIFT] && addr[SHIFT+1]) |=> (ptr_a == 4'd0));
  assert_read_clears_rxav_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && addr[SHIFT] && !addr[SHIFT+1] && !rx_valid[0]) |=> !rr0_b[0]);
  assert_vec_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60});
  assert_break_sets_R14: assert property (@(posedge clk) disable iff (!rst_n)
    brk[1] |=> rr0_a[7]);
endmodule

bind dual_serial_regs dual_serial_regs_chk #(.SHIFT(SHIFT)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd),
  .rx_valid(rx_valid), .brk(brk), .tx_strobe(tx_strobe),
  .rr0_b(rr0_q[0]), .rr0_a(rr0_q[1]), .ptr_b(ptr_q[0]), .ptr_a(ptr_q[1]),
  .vec(st_q.vec)
);

// File: tb/dual_serial_regs_tb_top.sv
module dual_serial_regs_tb_top;
  localparam int CLK_NS = 10;
  localparam int SH = 1;
  localparam int A = 1;
  localparam int B = 0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic b_wr = 0, b_rd = 0, b_ch = 0, b_dp = 0;
  logic [7:0] b_wd = 0;
  logic [1:0] b_rxv = 0, b_brk = 0;
  logic [7:0] b_rxd [2] = '{8'h00, 8'h00};
  logic [SH+1:0] addr;
  logic [7:0] rdata, tx_byte;
  logic irq;
  logic [1:0] tx_strobe;

  assign addr = {b_ch, b_dp} << SH;
  always #(CLK_NS/2) clk = ~clk;

  dual_serial_regs #(.SHIFT(SH)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(b_wd), .wr(b_wr), .rd(b_rd),
    .rdata(rdata), .irq(irq), .rx_valid(b_rxv), .rx_data({b_rxd[1], b_rxd[0]}),
    .brk(b_brk), .tx_strobe(tx_strobe), .tx_byte(tx_byte));

  int checks = 0, fails = 0;
  string req = "R9";

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  int mw [2][16];
  int m0 [2], m1 [2], m12 [2], m13 [2], mrx [2], mp [2];
  bit mri [2], mti [2], mrs [2], mts [2];
  int mvec, mr3, exp_rd, exp_stb, exp_byte;

  function automatic int vcode(int c, int src, int hi);
    if (src == 0) return hi ? 'h60 : 'h06;
    if (src == 1) return c == A ? (hi ? 'h30 : 'h0C) : (hi ? 'h20 : 'h04);
    return c == A ? (hi ? 'h10 : 'h08) : 'h00;
  endfunction

  function automatic int hib(int c);
    return (mw[c][9] >> 4) & 1;
  endfunction

  task automatic m_set_rx(int c);
    mri[c] = 1;
    if (!mts[c]) begin mrs[c] = 1; mvec = vcode(c, 1, hib(c)); end
    mr3 |= (c == A) ? 'h20 : 'h04;
  endtask
  task automatic m_set_tx(int c);
    mti[c] = 1;
    if (!mrs[c]) begin mts[c] = 1; mvec = vcode(c, 2, hib(c)); end
    mr3 |= (c == A) ? 'h10 : 'h02;
  endtask
  task automatic m_clr_rx(int c);
    mri[c] = 0; mrs[c] = 0; mvec = vcode(c, 0, hib(c));
    mr3 &= ~((c == A) ? 'h20 : 'h04);
    if (mti[c]) m_set_tx(c);
  endtask
  task automatic m_clr_tx(int c);
    mti[c] = 0; mts[c] = 0; mvec = vcode(c, 0, hib(c));
    mr3 &= ~((c == A) ? 'h10 : 'h02);
    if (mri[c]) m_set_rx(c);
  endtask
  task automatic m_reset(int c);
    for (int r = 0; r < 16; r++) mw[c][r] = 0;
    mw[c][4] = 'h04; mw[c][9] = 'hC0; mw[c][11] = 'h08; mw[c][14] = 'h30; mw[c][15] = 'hF8;
    m0[c] = 'h44; m1[c] = 'h07; m12[c] = 0; m13[c] = 0; mrx[c] = 0; mp[c] = 0;
    mri[c] = 0; mti[c] = 0; mrs[c] = 0; mts[c] = 0;
    if (c == B) mvec = 0; else mr3 = 0;
  endtask

  function automatic bit m_irq();
    bit q = 0;
    for (int c = 0; c < 2; c++) begin
      int m = mw[c][1] & 'h18;
      if (((mw[c][1] & 2) != 0) && mti[c]) q = 1;
      if ((m == 'h08 || m == 'h10) && mri[c]) q = 1;
      if (((mw[c][15] & 'h80) != 0) && ((m0[c] & 'h80) != 0)) q = 1;
    end
    return q;
  endfunction

  task automatic m_step();
    int c = b_ch;
    int rst = 0;
    exp_stb = 0;
    if (b_wr && !b_dp) begin
      if (mp[c] == 0) begin
        int cmd = b_wd & 'h38;
        mp[c] = (b_wd & 7) | ((cmd == 'h08) ? 8 : 0);
        if (cmd == 'h28) m_clr_tx(c);
        else if (cmd == 'h38) begin
          if (mrs[c]) m_clr_rx(c); else if (mts[c]) m_clr_tx(c);
        end
      end else begin
        int r = mp[c];
        mp[c] = 0;
        if (r == 9 && (b_wd >> 6) != 0) rst = b_wd >> 6;
        else mw[c][r] = b_wd;
        if (r == 12) m12[c] = b_wd;
        if (r == 13) m13[c] = b_wd;
      end
    end
    if (b_wr && b_dp) begin
      if ((mw[c][5] & 8) != 0) begin exp_stb = 1 << c; exp_byte = b_wd; end
      m0[c] |= 4; m1[c] |= 1;
      m_set_tx(c);
    end
    if (b_rd && !b_dp) begin
      case (mp[c])
        0: exp_rd = m0[c];
        1: exp_rd = m1[c];
        2: exp_rd = (c == B) ? mvec : 0;
        3: exp_rd = (c == A) ? mr3 : 0;
        12: exp_rd = m12[c];
        13: exp_rd = m13[c];
        default: exp_rd = 0;
      endcase
      mp[c] = 0;
    end
    if (b_rd && b_dp) begin
      exp_rd = mrx[c]; m0[c] &= ~1; m_clr_rx(c);
    end
    if (rst & 1) m_reset(B);
    if (rst & 2) m_reset(A);
    for (int k = 0; k < 2; k++) begin
      if (b_rxv[k] && (mw[k][3] & 1) && !(m0[k] & 1)) begin
        m0[k] |= 1; mrx[k] = b_rxd[k]; m_set_rx(k);
      end
      if (b_brk[k]) m0[k] |= 'h80;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    m_step();
    @(negedge clk);
    check({req, " irq"}, irq, m_irq());
    check({req, " tx_strobe"}, tx_strobe, exp_stb);
    if (exp_stb != 0) check({req, " tx_byte"}, tx_byte, exp_byte);
    if (b_rd) check({req, " rdata"}, rdata, exp_rd);
    b_wr = 0; b_rd = 0; b_rxv = 0; b_brk = 0;
  endtask

  task automatic do_wr(int c, int dp, int v);
    b_ch = c[0]; b_dp = dp[0]; b_wd = v[7:0]; b_wr = 1; tick();
  endtask
  task automatic do_rd(int c, int dp, output logic [7:0] v);
    b_ch = c[0]; b_dp = dp[0]; b_rd = 1; tick(); v = rdata;
  endtask
  task automatic wreg(int c, int r, int v);
    if (r != 0) do_wr(c, 0, r);
    do_wr(c, 0, v);
  endtask
  task automatic rreg(int c, int r, output logic [7:0] v);
    if (r != 0) do_wr(c, 0, r);
    do_rd(c, 0, v);
  endtask
  task automatic rx(int c, int d);
    b_rxv[c] = 1; b_rxd[c] = d[7:0]; tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    m_reset(B); m_reset(A); exp_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R9 reset irq", irq, 0);
    rreg(A, 0, v); check("R9 status reset", v, 8'h44);
    rreg(A, 1, v); check("R9 reg1 reset", v, 8'h07);
    rreg(B, 2, v); check("R9 vector reset", v, 8'h00);

    req = "R13";
    wreg(A, 12, 'h5A); rreg(A, 12, v); check("R13 mirror 12", v, 8'h5A);
    wreg(A, 13, 'h3C); rreg(A, 13, v); check("R13 mirror 13", v, 8'h3C);
    req = "R1";
    rreg(B, 12, v); check("R1 channel separation", v, 8'h00);
    req = "R3";
    do_rd(A, 0, v); check("R3 pointer back to 0", v, 8'h44);
    req = "R2";
    do_wr(A, 0, 'h0D); do_rd(A, 0, v); check("R2 high pointer", v, 8'h3C);

    req = "R12";
    wreg(B, 3, 1); wreg(B, 1, 'h10); rx(B, 'hA5);
    rreg(B, 0, v); check("R12 rx accepted", v, 8'h45);
    check("R8 rx irq", irq, 1);
    rreg(B, 2, v); check("R6 rx B low vector", v, 8'h04);
    rreg(A, 3, v); check("R7 rx B pending bit", v, 8'h04);
    rx(B, 'h11);
    req = "R11";
    do_rd(B, 1, v); check("R11 data read keeps first byte", v, 8'hA5);
    check("R11 irq cleared", irq, 0);
    rreg(B, 0, v); check("R11 rx avail cleared", v, 8'h44);
    req = "R12";
    rx(A, 'h99); rreg(A, 0, v); check("R12 rx disabled ignored", v, 8'h44);

    req = "R10";
    wreg(A, 5, 8); wreg(A, 1, 2);
    do_wr(A, 1, 'h77);
    check("R10 tx strobe A", tx_strobe, 2'b10);
    check("R10 tx byte", tx_byte, 8'h77);
    check("R8 tx irq", irq, 1);
    rreg(B, 2, v); check("R6 tx A low vector", v, 8'h08);
    rreg(A, 3, v); check("R7 tx A pending bit", v, 8'h10);
    rreg(A, 1, v); check("R10 all sent", v, 8'h07);
    req = "R4";
    do_wr(A, 0, 'h28);
    check("R4 tx clear irq", irq, 0);
    rreg(B, 2, v); check("R4 vector idle", v, 8'h06);
    req = "R10";
    do_wr(B, 1, 'h33);
    check("R10 disabled tx not forwarded", tx_strobe, 2'b00);
    check("R8 tx irq masked", irq, 0);
    rreg(B, 2, v); check("R6 tx B vector", v, 8'h00);
    rreg(A, 3, v); check("R7 tx B pending bit", v, 8'h02);
    req = "R4";
    do_wr(B, 0, 'h38);
    rreg(B, 2, v); check("R4 ius clears tx", v, 8'h06);
    rreg(A, 3, v); check("R4 pending cleared", v, 8'h00);

    req = "R5";
    wreg(B, 1, 'h12); do_wr(B, 1, 'h01);
    rreg(B, 2, v); check("R5 tx in service", v, 8'h00);
    rx(B, 'h3C);
    rreg(B, 2, v); check("R5 rx waits", v, 8'h00);
    rreg(A, 3, v); check("R7 both B pending", v, 8'h06);
    do_wr(B, 0, 'h38);
    rreg(B, 2, v); check("R5 rx re-raised", v, 8'h04);
    check("R5 irq still high", irq, 1);
    do_rd(B, 1, v); check("R11 second byte", v, 8'h3C);
    rreg(B, 2, v); check("R5 idle after read", v, 8'h06);
    check("R8 irq low", irq, 0);

    req = "R6";
    wreg(B, 9, 'h10); rx(B, 'h42);
    rreg(B, 2, v); check("R6 rx B high vector", v, 8'h20);
    do_rd(B, 1, v);
    rreg(B, 2, v); check("R6 idle high vector", v, 8'h60);
    wreg(A, 9, 'h10); wreg(A, 3, 1); wreg(A, 1, 'h12); rx(A, 'h55);
    rreg(B, 2, v); check("R6 rx A high vector", v, 8'h30);
    req = "R5";
    do_wr(A, 1, 'h66);
    rreg(B, 2, v); check("R5 tx A waits", v, 8'h30);
    rreg(A, 3, v); check("R7 both A pending", v, 8'h30);
    do_rd(A, 1, v); check("R11 A byte", v, 8'h55);
    rreg(B, 2, v); check("R5 tx A re-raised high", v, 8'h10);
    req = "R4";
    do_wr(A, 0, 'h28);
    rreg(B, 2, v); check("R4 high idle", v, 8'h60);

    req = "R14";
    b_brk[A] = 1; tick();
    rreg(A, 0, v); check("R14 break status", v, 8'hC4);
    check("R8 break irq", irq, 1);
    req = "R9";
    wreg(A, 9, 'h80);
    check("R9 reset A irq", irq, 0);
    rreg(A, 0, v); check("R9 A status after reset", v, 8'h44);
    rreg(A, 12, v); check("R9 A reg12 cleared", v, 8'h00);
    rreg(B, 9, v); check("R9 B untouched", v, 8'h00);
    wreg(B, 9, 'hC0);
    rreg(B, 1, v); check("R9 B reg1 after reset", v, 8'h07);
    rreg(B, 2, v); check("R9 vector after full reset", v, 8'h00);
    repeat (2) tick();
    finish_run();
  end
endmodule